// File: doc/BRIEF.md
# DSP Data Address Generator

This block computes the data-memory address for load, store and multiply-accumulate operand fetches of a small DSP core. Each request carries a 3-bit addressing mode, the current value of a pointer register, a 16-bit instruction constant, and the top and bottom bounds of a circular buffer. The block returns the effective address, the updated pointer value to write back to the register file, and a write-back enable. In immediate mode the instruction constant comes back as a data value rather than an address, and a flag marks this.

Requests enter on a valid/ready handshake and results leave on another. A request is accepted in a cycle where `in_valid` and `in_ready` are both high. A result is taken in a cycle where `out_valid` and `out_ready` are both high. With `REG_OUT=1` (default) one register stage sits between the two sides. `in_ready` is high when that stage is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the held result does not change and no new request is accepted. With `REG_OUT=0` the path is combinational and `in_ready` follows `out_ready`.

All pointer and address arithmetic wraps modulo 2^AW. The circular mode lets a loop walk a sample buffer with no branch instructions. When the pointer has reached the buffer top, it is replaced by the buffer bottom before use.

Top module: `dag_addr_gen`

## Requirements
- R1: Mode code 0 (direct) gives `out_addr` = `in_imm`, with `out_wb_en` low and `out_is_data` low.
- R2: Mode code 1 (indirect) gives `out_addr` = `in_ptr` and `out_wb_en` low. In every mode that does not write back, `out_wb_ptr` equals the unchanged `in_ptr`.
- R3: Mode code 2 (post-increment) gives `out_addr` = `in_ptr`, `out_wb_ptr` = `in_ptr`+1 and `out_wb_en` high.
- R4: Mode code 3 (pre-decrement) gives `out_addr` = `out_wb_ptr` = `in_ptr`-1, with `out_wb_en` high.
- R5: Mode code 4 (circular post-increment) sets base to `in_bot` when `in_ptr` equals `in_top`, and to `in_ptr` otherwise. It gives `out_addr` = base, `out_wb_ptr` = base+1 and `out_wb_en` high. Feeding the write-back value back as the pointer walks the buffer bottom..top-1 in order, repeating.
- R6: Mode code 5 (immediate) gives `out_addr` = `in_imm`, `out_is_data` high and `out_wb_en` low. `out_is_data` is low in every other mode.
- R7: Reserved mode codes 6 and 7 give `out_addr` = 0, `out_wb_en` low and `out_is_data` low.
- R8: Address and pointer arithmetic wraps modulo 2^16: post-increment of 0xFFFF writes back 0x0000, and pre-decrement of 0x0000 gives 0xFFFF.
- R9: With `REG_OUT=1`, `out_valid` is low after reset. A request accepted at a clock edge appears on the outputs with `out_valid` high right after that edge.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and every output holds its value. When `out_ready` rises, the held result is taken and a waiting request is accepted at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_mode | input | 3 | Addressing mode code |
| in_ptr | input | AW | Pointer register value |
| in_imm | input | AW | Instruction constant |
| in_top | input | AW | Circular buffer top (wrap point) |
| in_bot | input | AW | Circular buffer bottom |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | AW | Effective address, or data value in immediate mode |
| out_wb_ptr | output | AW | Pointer value to write back |
| out_wb_en | output | 1 | Pointer write-back enable |
| out_is_data | output | 1 | `out_addr` carries an immediate value |

## Verification
Two events can fall in the same cycle: the circular wrap and a stalled output stage releasing. The wrap replaces the pointer and produces the wrapped address and the bottom+1 write-back in one step. The stall release drains a held result while a new request is accepted. The bench runs a 40-step walk of a 16-entry buffer, feeding each write-back value in as the next pointer, and compares every address and write-back value with a model built from the requirements. It also parks a wrap request behind a stalled result, then raises `out_ready`. It checks that the held result did not move during the stall and that the wrapped result appears right after the release edge.

// File: rtl/dag_pkg.sv
package dag_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_DIRECT   = 3'd0,
    MD_INDIRECT = 3'd1,
    MD_POSTINC  = 3'd2,
    MD_PREDEC   = 3'd3,
    MD_CIRC     = 3'd4,
    MD_IMM      = 3'd5,
    MD_RSV6     = 3'd6,
    MD_RSV7     = 3'd7
  } dag_mode_e;

  typedef enum logic [1:0] {
    AS_IMM  = 2'd0,
    AS_BASE = 2'd1,
    AS_DEC  = 2'd2,
    AS_ZERO = 2'd3
  } addr_sel_e;

  typedef enum logic [1:0] {
    WS_KEEP = 2'd0,
    WS_INC  = 2'd1,
    WS_DEC  = 2'd2
  } wb_sel_e;

  typedef struct packed {
    addr_sel_e addr_sel;
    wb_sel_e   wb_sel;
    logic      circ;
    logic      wb_en;
    logic      is_data;
  } dag_ctl_t;

endpackage

// File: rtl/dag_mode_decode.sv
module dag_mode_decode
  import dag_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output dag_ctl_t          ctl
);

  always_comb begin
    ctl = '{addr_sel: AS_ZERO, wb_sel: WS_KEEP, circ: 1'b0,
            wb_en: 1'b0, is_data: 1'b0};
    unique case (dag_mode_e'(mode))
      MD_DIRECT: begin
        ctl.addr_sel = AS_IMM;
      end
      MD_INDIRECT: begin
        ctl.addr_sel = AS_BASE;
      end
      MD_POSTINC: begin
        ctl.addr_sel = AS_BASE;
        ctl.wb_sel   = WS_INC;
        ctl.wb_en    = 1'b1;
      end
      MD_PREDEC: begin
        ctl.addr_sel = AS_DEC;
        ctl.wb_sel   = WS_DEC;
        ctl.wb_en    = 1'b1;
      end
      MD_CIRC: begin
        ctl.addr_sel = AS_BASE;
        ctl.wb_sel   = WS_INC;
        ctl.circ     = 1'b1;
        ctl.wb_en    = 1'b1;
      end
      MD_IMM: begin
        ctl.addr_sel = AS_IMM;
        ctl.is_data  = 1'b1;
      end
      MD_RSV6, MD_RSV7: begin
        ctl.addr_sel = AS_ZERO;
      end
      default: begin
        ctl.addr_sel = AS_ZERO;
      end
    endcase
  end

endmodule

// File: rtl/dag_ptr_arith.sv
module dag_ptr_arith
  import dag_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] imm,
  input  logic [AW-1:0] buf_top,
  input  logic [AW-1:0] buf_bot,
  input  dag_ctl_t      ctl,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] wb_val
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic          at_top;
  logic [AW-1:0] base;
  logic [AW-1:0] base_inc;
  logic [AW-1:0] base_dec;

  // Circular mode swaps in the bottom bound before the pointer is used.
  assign at_top   = (ptr == buf_top);
  assign base     = (ctl.circ && at_top) ? buf_bot : ptr;
  assign base_inc = base + ONE;
  assign base_dec = base - ONE;

  always_comb begin
    unique case (ctl.addr_sel)
      AS_IMM:  addr = imm;
      AS_BASE: addr = base;
      AS_DEC:  addr = base_dec;
      default: addr = '0;
    endcase
  end

  always_comb begin
    unique case (ctl.wb_sel)
      WS_INC:  wb_val = base_inc;
      WS_DEC:  wb_val = base_dec;
      default: wb_val = ptr;
    endcase
  end

endmodule

// File: rtl/dag_out_stage.sv
module dag_out_stage #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);

  generate
    if (REG_OUT) begin : g_reg
      logic         vld_q;
      logic [W-1:0] dat_q;
      logic         load;

      assign s_ready = !vld_q || m_ready;
      assign load    = s_valid && s_ready;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
        end else if (s_ready) begin
          vld_q <= s_valid;
        end
      end

      always_ff @(posedge clk) begin
        if (load) begin
          dat_q <= s_data;
        end
      end

      assign m_valid = vld_q;
      assign m_data  = dat_q;
    end else begin : g_pass
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign s_ready    = m_ready;
      assign m_valid    = s_valid;
      assign m_data     = s_data;
    end
  endgenerate

endmodule

// File: rtl/dag_addr_gen.sv
module dag_addr_gen
  import dag_pkg::*;
#(
  parameter int AW      = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [MODE_W-1:0] in_mode,
  input  logic [AW-1:0]     in_ptr,
  input  logic [AW-1:0]     in_imm,
  input  logic [AW-1:0]     in_top,
  input  logic [AW-1:0]     in_bot,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [AW-1:0]     out_addr,
  output logic [AW-1:0]     out_wb_ptr,
  output logic              out_wb_en,
  output logic              out_is_data
);

  localparam int PW = 2 * AW + 2;

  dag_ctl_t      ctl;
  logic [AW-1:0] addr_c;
  logic [AW-1:0] wb_c;
  logic [PW-1:0] pay_in;
  logic [PW-1:0] pay_out;

  dag_mode_decode u_dec (
    .mode (in_mode),
    .ctl  (ctl)
  );

  dag_ptr_arith #(.AW(AW)) u_arith (
    .ptr     (in_ptr),
    .imm     (in_imm),
    .buf_top (in_top),
    .buf_bot (in_bot),
    .ctl     (ctl),
    .addr    (addr_c),
    .wb_val  (wb_c)
  );

  assign pay_in = {addr_c, wb_c, ctl.wb_en, ctl.is_data};

  dag_out_stage #(.W(PW), .REG_OUT(REG_OUT)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (pay_in),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (pay_out)
  );

  assign {out_addr, out_wb_ptr, out_wb_en, out_is_data} = pay_out;

endmodule

// File: rtl/dag_addr_gen_chk.sv
module dag_addr_gen_chk #(
  parameter int AW      = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [2:0]    in_mode,
  input logic [AW-1:0] in_ptr,
  input logic [AW-1:0] in_imm,
  input logic [AW-1:0] in_top,
  input logic [AW-1:0] in_bot,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic [AW-1:0] out_wb_ptr,
  input logic          out_wb_en,
  input logic          out_is_data
);

  p_data_no_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_data |-> !out_wb_en);

  generate
    if (REG_OUT) begin : g_reg
      p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

      p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

      p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr)
          && $stable(out_wb_ptr) && $stable(out_wb_en) && $stable(out_is_data));

      p_direct_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_mode == 3'd0 |=>
          out_addr == $past(in_imm) && !out_wb_en);

      p_postinc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_mode == 3'd2 |=>
          out_wb_en && out_addr == $past(in_ptr)
          && out_wb_ptr == AW'($past(in_ptr) + 1'b1));

      p_circ_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_mode == 3'd4 && in_ptr == in_top |=>
          out_addr == $past(in_bot) && out_wb_en);

      p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_mode[2:1] == 2'b11 |=>
          !out_wb_en && !out_is_data);
    end else begin : g_comb
      p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == out_ready);

      p_direct_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_mode == 3'd0 |-> out_addr == in_imm && !out_wb_en);

      p_postinc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_mode == 3'd2 |->
          out_wb_en && out_addr == in_ptr && out_wb_ptr == AW'(in_ptr + 1'b1));

      p_circ_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_mode == 3'd4 && in_ptr == in_top |->
          out_addr == in_bot && out_wb_en);

      p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_mode[2:1] == 2'b11 |-> !out_wb_en && !out_is_data);
    end
  endgenerate

endmodule

bind dag_addr_gen dag_addr_gen_chk #(.AW(AW), .REG_OUT(REG_OUT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_mode     (in_mode),
  .in_ptr      (in_ptr),
  .in_imm      (in_imm),
  .in_top      (in_top),
  .in_bot      (in_bot),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_addr    (out_addr),
  .out_wb_ptr  (out_wb_ptr),
  .out_wb_en   (out_wb_en),
  .out_is_data (out_is_data)
);

// File: tb/dag_addr_gen_bench.sv
module dag_addr_gen_bench;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2:0]    in_mode = '0;
  logic [AW-1:0] in_ptr = '0;
  logic [AW-1:0] in_imm = '0;
  logic [AW-1:0] in_top = '0;
  logic [AW-1:0] in_bot = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [AW-1:0] out_addr;
  logic [AW-1:0] out_wb_ptr;
  logic          out_wb_en;
  logic          out_is_data;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dag_addr_gen #(.AW(AW), .REG_OUT(1'b1)) u_dag_addr_gen (
    .clk, .rst_n, .in_valid, .in_ready, .in_mode, .in_ptr, .in_imm,
    .in_top, .in_bot, .out_valid, .out_ready, .out_addr, .out_wb_ptr,
    .out_wb_en, .out_is_data
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Present one request, let it be accepted, then drop valid.
  task automatic issue(input logic [2:0] m, input logic [AW-1:0] p,
                       input logic [AW-1:0] im, input logic [AW-1:0] tp,
                       input logic [AW-1:0] bt);
    @(negedge clk);
    in_mode = m; in_ptr = p; in_imm = im; in_top = tp; in_bot = bt;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic chk_out(input string req, input logic [AW-1:0] ea,
                         input logic [AW-1:0] ew, input logic een,
                         input logic edat);
    chk(req, "valid", 32'(out_valid), 32'd1);
    chk(req, "addr", 32'(out_addr), 32'(ea));
    chk(req, "wb_ptr", 32'(out_wb_ptr), 32'(ew));
    chk(req, "wb_en", 32'(out_wb_en), 32'(een));
    chk(req, "is_data", 32'(out_is_data), 32'(edat));
  endtask

  task automatic t_reset();
    chk("R9", "valid after reset", 32'(out_valid), 32'd0);
    chk("R9", "ready after reset", 32'(in_ready), 32'd1);
  endtask

  task automatic t_direct_indirect();
    issue(3'd0, 16'h1234, 16'hBEEF, 16'h0, 16'h0);
    chk_out("R1", 16'hBEEF, 16'h1234, 1'b0, 1'b0);
    issue(3'd1, 16'h0A0A, 16'h5555, 16'h0, 16'h0);
    chk_out("R2", 16'h0A0A, 16'h0A0A, 1'b0, 1'b0);
  endtask

  task automatic t_inc_dec();
    issue(3'd2, 16'h0040, 16'h0, 16'h0, 16'h0);
    chk_out("R3", 16'h0040, 16'h0041, 1'b1, 1'b0);
    issue(3'd3, 16'h0040, 16'h0, 16'h0, 16'h0);
    chk_out("R4", 16'h003F, 16'h003F, 1'b1, 1'b0);
  endtask

  task automatic t_wrap16();
    issue(3'd2, 16'hFFFF, 16'h0, 16'h0, 16'h0);
    chk_out("R8", 16'hFFFF, 16'h0000, 1'b1, 1'b0);
    issue(3'd3, 16'h0000, 16'h0, 16'h0, 16'h0);
    chk_out("R8", 16'hFFFF, 16'hFFFF, 1'b1, 1'b0);
  endtask

  task automatic t_imm_reserved();
    issue(3'd5, 16'h7777, 16'hC0DE, 16'h0, 16'h0);
    chk_out("R6", 16'hC0DE, 16'h7777, 1'b0, 1'b1);
    issue(3'd6, 16'h1111, 16'h2222, 16'h1111, 16'h3333);
    chk_out("R7", 16'h0000, 16'h1111, 1'b0, 1'b0);
    issue(3'd7, 16'h4444, 16'h2222, 16'h0, 16'h0);
    chk_out("R7", 16'h0000, 16'h4444, 1'b0, 1'b0);
  endtask

  // 16-entry buffer 0x0100..0x010F, wrap point 0x0110, 40 accesses.
  task automatic t_circ_walk();
    logic [AW-1:0] p = 16'h0100;
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] base = (p == 16'h0110) ? 16'h0100 : p;
      issue(3'd4, p, 16'h0, 16'h0110, 16'h0100);
      chk("R5", "walk addr", 32'(out_addr), 32'(base));
      chk("R5", "walk wb", 32'(out_wb_ptr), 32'(base + 16'd1));
      p = out_wb_ptr;
    end
    chk("R5", "walk last ptr", 32'(p), 32'h0108);
  endtask

  // Stall a result, park a wrapping request behind it, then release.
  task automatic t_stall_wrap();
    @(negedge clk);
    out_ready = 1'b0;
    issue(3'd2, 16'h0200, 16'h0, 16'h0, 16'h0);
    chk("R10", "stall valid", 32'(out_valid), 32'd1);
    chk("R10", "stall ready", 32'(in_ready), 32'd0);
    in_mode = 3'd4; in_ptr = 16'h0310; in_top = 16'h0310; in_bot = 16'h0300;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R10", "held addr", 32'(out_addr), 32'h0200);
    chk("R10", "held wb", 32'(out_wb_ptr), 32'h0201);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk_out("R10", 16'h0300, 16'h0301, 1'b1, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk("R9", "drained", 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direct_indirect();
    t_inc_dec();
    t_wrap16();
    t_imm_reserved();
    t_circ_walk();
    t_stall_wrap();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule